// File: doc/BRIEF.md
# Burst ROM Read Sequencer

This block reads burst-capable (nibble-mode) ROM on an external bus. A requester presents a start address, the ROM port width (8, 16 or 32 bits), a 2-bit burst setting, a wait-state count and a qualifier that tells the sequencer to disregard the external WAIT input. Once the request is taken, the sequencer drives chip select and read strobe low for the whole burst. Between beats, only the address moves. Each beat's data is captured from the bus and handed back with a one-clock valid strobe. A done flag marks the final beat.

The controller has three states. `S_IDLE` waits for a request. `S_FIRST` runs the first beat with normal-access timing. `S_NEXT` runs every later beat. The transitions are:
- `S_IDLE` to `S_FIRST` on request acceptance.
- `S_FIRST` to `S_NEXT` when the first beat completes and more beats follow.
- `S_FIRST` to `S_IDLE` when a single access completes.
- `S_NEXT` to `S_NEXT` on each completed middle beat.
- `S_NEXT` to `S_IDLE` when the last beat completes.

A beat completes on the cycle its down-counter is zero and no WAIT is being honoured. A honoured WAIT keeps the state and the counter where they are.

Top module: `burst_rom_rd`

## Requirements
- R1: `req_ready` is 1 only in idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Chip select is low from the next cycle, and no other request is taken until the burst ends.
- R2: Beat count comes from `req_burst`: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16. The count is then clamped to the width's maximum. The maximum is 16 for width code 0 (8-bit), 8 for code 1 (16-bit), and 4 for codes 2 and 3 (32-bit).
- R3: `rom_cs_n` and `rom_rd_n` stay low without a gap from the first cycle of the first beat to the last cycle of the last beat. Both are high in idle.
- R4: The first beat addresses `req_addr`. Each later beat adds the port width in bytes: 1, 2 or 4.
- R5: The first beat takes 1+W cycles, where W is `req_waits`. WAIT is sampled on its final cycle only when W is at least 1.
- R6: Every later beat takes 1+max(W,1) cycles, so it takes 2 cycles when W is 0. WAIT is always sampled on its final cycle.
- R7: A sampled `rom_wait` of 1 on a beat's final cycle stretches the beat by one cycle. The check repeats on each following cycle.
- R8: When `req_wait_ign` was 1 at acceptance, `rom_wait` has no effect on beat timing.
- R9: `rd_valid` pulses for one cycle right after each beat's final cycle. At the same time, `rd_data` holds the `rom_data` sampled on that final cycle.
- R10: `done` pulses together with the `rd_valid` of the last beat. A burst setting of 0 makes a single access.
- R11: After reset, `req_ready` is 1, `rom_cs_n` and `rom_rd_n` are 1, and `rd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | AW | Start byte address |
| req_width | input | 2 | Port width code: 0=8, 1=16, 2/3=32 bits |
| req_burst | input | 2 | Burst setting, 0 = single access |
| req_waits | input | WAIT_W | Wait-state count W |
| req_wait_ign | input | 1 | Disregard WAIT for this transfer |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_rd_n | output | 1 | ROM read strobe, active low |
| rom_addr | output | AW | ROM byte address |
| rom_data | input | DW | ROM read data |
| rom_wait | input | 1 | External wait request, active high |
| rd_valid | output | 1 | One-cycle data valid pulse |
| rd_data | output | DW | Captured beat data |
| done | output | 1 | Last beat delivered |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, and a 4-bit wait count. This lets it reach the longest 16-beat burst on an 8-bit port and wait settings from 0 up to the maximum of 15. Random requests cover every width code and burst setting, including the clamped combinations, with wait counts 0 to 3 and WAIT toggling at random. Directed runs add a full 16-beat burst with zero waits, a single access with WAIT held high and W=0, the 15-wait maximum, and an ignored WAIT held high for a whole burst.

// File: rtl/brom_pkg.sv
package brom_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FIRST = 2'd1,
        S_NEXT  = 2'd2
    } brom_state_t;

    localparam int BEAT_CNT_W = 4;
endpackage

// File: rtl/brom_len_map.sv
module brom_len_map
    import brom_pkg::*;
(
    input  logic [1:0]            width,
    input  logic [1:0]            burst,
    output logic [BEAT_CNT_W-1:0] last_idx
);
    logic [4:0] asked;
    logic [4:0] cap;
    logic [4:0] beats;

    always_comb begin
        unique case (burst)
            2'd0: asked = 5'd1;
            2'd1: asked = 5'd4;
            2'd2: asked = 5'd8;
            default: asked = 5'd16;
        endcase
        unique case (width)
            2'd0: cap = 5'd16;
            2'd1: cap = 5'd8;
            default: cap = 5'd4;
        endcase
        beats    = (asked > cap) ? cap : asked;
        last_idx = BEAT_CNT_W'(beats - 5'd1);
    end

    // R2: resulting length never exceeds the width's limit
    always_comb begin
        a_r2_len_legal: assert (width == 2'd0 || (width == 2'd1 ? last_idx <= 4'd7 : last_idx <= 4'd3));
    end
endmodule

// File: rtl/brom_addr_step.sv
module brom_addr_step #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] start,
    input  logic [1:0]    width,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] step;

    always_comb begin
        unique case (width)
            2'd0: step = AW'(1);
            2'd1: step = AW'(2);
            default: step = AW'(4);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= start;
        else if (adv)  addr <= addr + step;
    end
endmodule

// File: rtl/burst_rom_rd.sv
module burst_rom_rd
    import brom_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_width,
    input  logic [1:0]        req_burst,
    input  logic [WAIT_W-1:0] req_waits,
    input  logic              req_wait_ign,
    output logic              rom_cs_n,
    output logic              rom_rd_n,
    output logic [AW-1:0]     rom_addr,
    input  logic [DW-1:0]     rom_data,
    input  logic              rom_wait,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              done
);
    localparam logic [WAIT_W-1:0] ONE_W = WAIT_W'(1);

    brom_state_t           state_q, state_d;
    logic [WAIT_W-1:0]     cnt_q, cnt_d, waits_q, later_len;
    logic [BEAT_CNT_W-1:0] beat_q, beat_d, last_q, last_map;
    logic [1:0]            width_q;
    logic                  ign_q, busy, take, samp_en, beat_end, is_last;

    brom_len_map u_len (
        .width    (req_width),
        .burst    (req_burst),
        .last_idx (last_map)
    );

    brom_addr_step #(.AW(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take),
        .adv   (beat_end && !is_last),
        .start (req_addr),
        .width (width_q),
        .addr  (rom_addr)
    );

    // output and qualifier decode
    always_comb begin
        busy      = (state_q != S_IDLE);
        req_ready = !busy;
        rom_cs_n  = !busy;
        rom_rd_n  = !busy;
        take      = req_valid && req_ready;
        samp_en   = !ign_q && (state_q == S_NEXT || waits_q != '0);
        beat_end  = busy && (cnt_q == '0) && !(samp_en && rom_wait);
        is_last   = (beat_q == last_q);
        later_len = (waits_q == '0) ? ONE_W : waits_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        beat_d  = beat_q;
        unique case (state_q)
            S_IDLE: begin
                if (take) begin
                    state_d = S_FIRST;
                    cnt_d   = req_waits;
                    beat_d  = '0;
                end
            end
            S_FIRST, S_NEXT: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - ONE_W;
                end else if (beat_end) begin
                    if (is_last) begin
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_NEXT;
                        cnt_d   = later_len;
                        beat_d  = beat_q + 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            beat_q  <= '0;
            last_q  <= '0;
            waits_q <= '0;
            width_q <= '0;
            ign_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            beat_q  <= beat_d;
            if (take) begin
                last_q  <= last_map;
                waits_q <= req_waits;
                width_q <= req_width;
                ign_q   <= req_wait_ign;
            end
        end
    end

    // returned data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= beat_end;
            done     <= beat_end && is_last;
            if (beat_end) rd_data <= rom_data;
        end
    end

    a_r3_strobes_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!rom_cs_n && !rom_rd_n));
    a_r1_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(last_q));
    a_r7_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == '0 && samp_en && rom_wait) |=> !rd_valid);
    a_r8_ign_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ign_q && cnt_q == '0) |=> rd_valid);
    a_r10_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_valid);
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !done) |-> (rom_addr - $past(rom_addr)) == (width_q == 2'd0 ? AW'(1) : width_q == 2'd1 ? AW'(2) : AW'(4)));
endmodule

// File: tb/burst_rom_rd_tb.sv
`timescale 1ns/1ps
module burst_rom_rd_tb;
    localparam int AW = 32, DW = 32, WAIT_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_width = '0, req_burst = '0;
    logic [WAIT_W-1:0] req_waits = '0;
    logic req_wait_ign = 1'b0;
    logic rom_cs_n, rom_rd_n, rom_wait = 1'b0, rd_valid, done;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data, rd_data;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] dfn(input logic [AW-1:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction
    assign rom_data = dfn(rom_addr);

    function automatic int exp_len(input logic [1:0] w, input logic [1:0] b);
        int n, cap;
        n = (b == 0) ? 1 : (4 << (b - 1));
        cap = (w == 0) ? 16 : (w == 1) ? 8 : 4;
        return (n > cap) ? cap : n;
    endfunction

    burst_rom_rd #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic run(input logic [AW-1:0] a, input logic [1:0] w, input logic [1:0] b,
                       input int wt, input bit ign, input int wprob, input bit wforce);
        int len, beat, k, m, step;
        bit sen, wv, pend;
        logic [AW-1:0] ea;
        logic [DW-1:0] pd;
        len = exp_len(w, b); step = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready idle", req_ready, 1);
        req_valid = 1; req_addr = a; req_width = w; req_burst = b;
        req_waits = WAIT_W'(wt); req_wait_ign = ign;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_addr = ~a;
        beat = 0; k = 1; ea = a; pend = 0; pd = '0;
        while (1) begin
            chk(rom_cs_n === 1'b0 && rom_rd_n === 1'b0, "R3 strobes low", {rom_cs_n, rom_rd_n}, 0);
            chk(req_ready === 1'b0, "R1 busy", req_ready, 0);
            chk(rom_addr === ea, "R4 address", rom_addr, ea);
            chk(rd_valid === pend, "R9 valid timing", rd_valid, pend);
            if (pend) chk(rd_data === pd, "R9 data", rd_data, pd);
            chk(done === 1'b0, "R10 done early", done, 0);
            wv = wforce ? 1'b1 : (($urandom % 100) < wprob);
            rom_wait = wv;
            sen = !ign && (beat > 0 || wt > 0);
            m = (beat == 0) ? 1 + wt : 1 + ((wt == 0) ? 1 : wt);
            if (k >= m && !(sen && wv)) begin
                pend = 1; pd = dfn(ea); beat++; k = 1;
                if (beat == len) break;
                ea = ea + step;
            end else begin
                pend = 0; k++;
            end
            @(posedge clk); @(negedge clk);
        end
        @(posedge clk); @(negedge clk);
        rom_wait = 0;
        chk(rd_valid === 1'b1 && rd_data === pd, "R9 last data", rd_data, pd);
        chk(done === 1'b1, "R10 done pulse", done, 1);
        chk(rom_cs_n === 1'b1 && rom_rd_n === 1'b1, "R3 released", {rom_cs_n, rom_rd_n}, 3);
        chk(req_ready === 1'b1, "R1 ready after", req_ready, 1);
        @(negedge clk);
        chk(rd_valid === 1'b0 && done === 1'b0, "R9 single pulse", {rd_valid, done}, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        #20 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1 && rom_cs_n === 1 && rom_rd_n === 1, "R11 reset ctrl",
            {req_ready, rom_cs_n, rom_rd_n}, 7);
        chk(rd_valid === 0 && done === 0, "R11 reset flags", {rd_valid, done}, 0);
        // R2 R6: full 16-beat 8-bit burst, zero waits
        run(32'h1000, 2'd0, 2'd3, 0, 0, 0, 0);
        // R2: clamped lengths for 16/32-bit ports
        run(32'h2000, 2'd2, 2'd3, 1, 0, 30, 0);
        run(32'h3002, 2'd1, 2'd3, 0, 0, 30, 0);
        run(32'h3100, 2'd3, 2'd2, 2, 0, 30, 0);
        // R5 R10: single access, W=0, WAIT high ignored on first beat
        run(32'h4000, 2'd0, 2'd0, 0, 0, 0, 1);
        // R5: maximum wait setting
        run(32'h4100, 2'd1, 2'd1, 15, 0, 20, 0);
        // R8: WAIT held high but qualifier set
        run(32'h5000, 2'd0, 2'd2, 1, 1, 0, 1);
        // R7: random bursts with random WAIT
        for (int i = 0; i < 40; i++)
            run($urandom, 2'($urandom), 2'($urandom), $urandom % 4, 1'($urandom % 4 == 0), 35, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule